// File: doc/BRIEF.md
# Link Power-Status Interface State Controller

This block sits on the physical-layer side of a link interface and decides, from the link's power-status input, whether that interface is usable. It tracks four states: disabled, reset, initializing and operational. Only the operational state lets requests and status flow. While the interface is not operational, requests coming in on the LREQ path are blocked and status events are dropped. Each time the controller enters reset or disabled, it fires one-cycle clear strobes that empty the pending-request holder and the status queue.

The power-status input is first passed through a synchronizer. It is then read in one of two ways:
- **Level mode:** a high synchronized value means the link is present.
- **Pulsed mode:** the link counts as present while rising edges keep arriving within a window of cycles.

Pulsed mode is chosen by a select input. It is forced whenever the isolation input reports a barrier between the two sides.

When presence is lost, the controller goes to reset straight away. A short dropout therefore only costs a re-initialization. If presence stays lost for a programmed number of cycles, the controller falls to disabled. When presence returns, the controller spends a programmed number of cycles initializing and then becomes operational.

Top module: `lps_iface_ctrl`

## Requirements
- R1: After reset, `if_state_o` is disabled (2'b00), both clear strobes are low and both pass outputs are low.
- R2: While presence holds, the state goes from disabled or reset to initializing (2'b10). After INIT_CYC consecutive cycles there, it becomes operational (2'b11).
- R3: Loss of presence in the operational state moves the state to reset (2'b01). `flush_req_o` and `flush_stat_o` are both high for exactly the first cycle in which the new state is shown.
- R4: If presence stays lost for DIS_LIM cycles counted from entry to reset, the state becomes disabled (2'b00). Both clear strobes pulse for one cycle on that entry.
- R5: If presence returns while in reset or disabled, the state goes to initializing, and no clear strobe fires on that entry.
- R6: `lreq_pass_o` equals `lreq_i` and `stat_pass_o` equals `stat_evt_i` while the state is operational. In every other state both are 0, including the cycle in which a clear strobe fires.
- R7: In pulsed mode, presence holds in the cycle that sees a rising edge of the synchronized input and for PULSE_WIN cycles after it. A longer gap between edges counts as loss of presence.
- R8: When `isolated_i` is 1, pulsed mode applies whatever `pulse_sel_i` says. A steadily high input then does not count as presence.
- R9: In level mode, a change of `link_pwr_i` first affects the state SYNC_STAGES+1 clock edges after it is sampled.
- R10: Loss of presence during initialization moves the state to reset and fires the clear strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_pwr_i | input | 1 | Link power-status input, asynchronous |
| pulse_sel_i | input | 1 | 1 selects pulsed interpretation |
| isolated_i | input | 1 | 1 reports an isolation barrier and forces pulsed mode |
| lreq_i | input | 1 | Incoming request strobe from the serial request path |
| stat_evt_i | input | 1 | Status event offered for queueing |
| if_state_o | output | 2 | 00 disabled, 01 reset, 10 initializing, 11 operational |
| lreq_pass_o | output | 1 | Request strobe accepted toward the decoder |
| stat_pass_o | output | 1 | Status event accepted into the queue |
| flush_req_o | output | 1 | One-cycle clear of pending bus and register-read requests |
| flush_stat_o | output | 1 | One-cycle clear of the status queue |

## Verification
Two events can meet in one cycle here: a request or status event arriving, and the state leaving operational. In that cycle the clear strobe fires and the pass gate closes at the same moment. The bench provokes this by holding `lreq_i` and `stat_evt_i` high across every presence drop, in both level and pulsed mode. A behavioural model then checks, each clock, that the event is not passed in the strobe cycle and that the strobe still lasts exactly one cycle. Presence returning in the same cycle that the reset dwell count expires is also swept, by varying the dropout length across DIS_LIM.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        ST_DIS  = 2'b00,
        ST_RST  = 2'b01,
        ST_INIT = 2'b10,
        ST_OPER = 2'b11
    } if_state_e;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lps_activity.sv
module lps_activity #(
    parameter int PULSE_WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic pulsed_i,
    output logic act_o
);
    localparam int AGE_W = $clog2(PULSE_WIN + 1);
    localparam logic [AGE_W-1:0] WIN = AGE_W'(PULSE_WIN);

    typedef struct packed {
        logic             prev;
        logic [AGE_W-1:0] age;
    } act_regs_t;

    act_regs_t r_d, r_q;
    logic      rise;

    always_comb begin
        r_d      = r_q;
        rise     = lvl_i & ~r_q.prev;
        r_d.prev = lvl_i;
        if (rise)               r_d.age = '0;
        else if (r_q.age < WIN) r_d.age = r_q.age + 1'b1;
        if (pulsed_i) act_o = rise | (r_q.age < WIN);
        else          act_o = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev <= 1'b0;
            r_q.age  <= WIN;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
#(
    parameter int DIS_LIM  = 16,
    parameter int INIT_CYC = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      act_i,
    output if_state_e state_o,
    output logic      flush_req_o,
    output logic      flush_stat_o
);
    localparam int MAXC  = (DIS_LIM > INIT_CYC) ? DIS_LIM : INIT_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DIS_END  = CNT_W'(DIS_LIM - 1);
    localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_CYC - 1);

    typedef struct packed {
        if_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             fl_req;
        logic             fl_stat;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      entering_idle;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_OPER: begin
                if (!act_i) begin
                    r_d.st  = ST_RST;
                    r_d.cnt = '0;
                end
            end
            ST_RST: begin
                if (act_i) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                end else if (r_q.cnt == DIS_END) begin
                    r_d.st  = ST_DIS;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DIS: begin
                if (act_i) begin
                    r_d.st  = ST_INIT;
                    r_d.cnt = '0;
                end
            end
            ST_INIT: begin
                if (!act_i) begin
                    r_d.st  = ST_RST;
                    r_d.cnt = '0;
                end else if (r_q.cnt == INIT_END) begin
                    r_d.st  = ST_OPER;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.st  = ST_DIS;
                r_d.cnt = '0;
            end
        endcase
        entering_idle = ((r_d.st == ST_RST) || (r_d.st == ST_DIS)) && (r_d.st != r_q.st);
        r_d.fl_req    = entering_idle;
        r_d.fl_stat   = entering_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_DIS;
            r_q.cnt     <= '0;
            r_q.fl_req  <= 1'b0;
            r_q.fl_stat <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o      = r_q.st;
    assign flush_req_o  = r_q.fl_req;
    assign flush_stat_o = r_q.fl_stat;
endmodule

// File: rtl/lps_iface_ctrl.sv
module lps_iface_ctrl
    import lps_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_WIN   = 8,
    parameter int DIS_LIM     = 16,
    parameter int INIT_CYC    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_pwr_i,
    input  logic       pulse_sel_i,
    input  logic       isolated_i,
    input  logic       lreq_i,
    input  logic       stat_evt_i,
    output logic [1:0] if_state_o,
    output logic       lreq_pass_o,
    output logic       stat_pass_o,
    output logic       flush_req_o,
    output logic       flush_stat_o
);
    logic      pwr_sync;
    logic      pulsed;
    logic      present;
    if_state_e st;
    logic      is_oper;

    assign pulsed = pulse_sel_i | isolated_i;

    lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (link_pwr_i),
        .q_o   (pwr_sync)
    );

    lps_activity #(.PULSE_WIN(PULSE_WIN)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (pwr_sync),
        .pulsed_i (pulsed),
        .act_o    (present)
    );

    lps_fsm #(.DIS_LIM(DIS_LIM), .INIT_CYC(INIT_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (present),
        .state_o      (st),
        .flush_req_o  (flush_req_o),
        .flush_stat_o (flush_stat_o)
    );

    assign is_oper     = (st == ST_OPER);
    assign if_state_o  = st;
    assign lreq_pass_o = lreq_i & is_oper;
    assign stat_pass_o = stat_evt_i & is_oper;
endmodule

// File: rtl/lps_iface_ctrl_chk.sv
module lps_iface_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lreq_i,
    input logic       stat_evt_i,
    input logic [1:0] if_state_o,
    input logic       lreq_pass_o,
    input logic       stat_pass_o,
    input logic       flush_req_o,
    input logic       flush_stat_o
);
    // R3: both strobes fire together
    p_strobe_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o == flush_stat_o);

    // R3 / R4: a strobe only in the first cycle of reset or disabled
    p_strobe_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> (if_state_o[1] == 1'b0) && (if_state_o != $past(if_state_o)));

    // R3: strobe lasts one cycle
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |=> !flush_req_o);

    // R6: gates closed outside operational
    p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_state_o != 2'b11) |-> (!lreq_pass_o && !stat_pass_o));

    // R6: gates follow inputs when operational
    p_gate_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_state_o == 2'b11) |-> (lreq_pass_o == lreq_i) && (stat_pass_o == stat_evt_i));

    // R2: operational is only reached from initializing
    p_oper_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_state_o == 2'b11) |-> $past(if_state_o) == 2'b10);

    // R4: disabled is only reached from reset
    p_dis_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_state_o == 2'b00) |-> $past(if_state_o) == 2'b01);

    // R5: no strobe while initializing
    p_init_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (if_state_o == 2'b10) |-> !flush_req_o && !flush_stat_o);
endmodule

bind lps_iface_ctrl lps_iface_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lreq_i       (lreq_i),
    .stat_evt_i   (stat_evt_i),
    .if_state_o   (if_state_o),
    .lreq_pass_o  (lreq_pass_o),
    .stat_pass_o  (stat_pass_o),
    .flush_req_o  (flush_req_o),
    .flush_stat_o (flush_stat_o)
);

// File: tb/lps_iface_ctrl_tb_top.sv
`timescale 1ns/1ps
module lps_iface_ctrl_tb_top;
    localparam int SYNC = 2;
    localparam int WIN  = 8;
    localparam int DLIM = 16;
    localparam int ICYC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_pwr_i = 1'b0;
    logic       pulse_sel_i = 1'b0;
    logic       isolated_i = 1'b0;
    logic       lreq_i = 1'b0;
    logic       stat_evt_i = 1'b0;
    logic [1:0] if_state_o;
    logic       lreq_pass_o, stat_pass_o, flush_req_o, flush_stat_o;

    int total = 0;
    int bad   = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    lps_iface_ctrl #(
        .SYNC_STAGES(SYNC), .PULSE_WIN(WIN), .DIS_LIM(DLIM), .INIT_CYC(ICYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .link_pwr_i(link_pwr_i),
        .pulse_sel_i(pulse_sel_i), .isolated_i(isolated_i),
        .lreq_i(lreq_i), .stat_evt_i(stat_evt_i),
        .if_state_o(if_state_o), .lreq_pass_o(lreq_pass_o),
        .stat_pass_o(stat_pass_o), .flush_req_o(flush_req_o),
        .flush_stat_o(flush_stat_o)
    );

    // behavioural reference
    bit m_pipe[$];
    bit m_prev;
    int m_age, m_state, m_cnt;
    bit m_flush;
    int since_edge;

    task automatic model_reset();
        m_pipe = {};
        for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);
        m_prev = 0; m_age = WIN; m_state = 0; m_cnt = 0; m_flush = 0;
    endtask

    task automatic model_clock(bit pin, bit pmode, bit iso);
        bit lvl, rise, present;
        int nxt;
        lvl = m_pipe[SYNC-1];
        rise = lvl && !m_prev;
        present = (pmode || iso) ? (rise || (m_age < WIN)) : lvl;
        nxt = m_state;
        if (m_state == 3) begin
            if (!present) begin nxt = 1; m_cnt = 0; end
        end else if (m_state == 1) begin
            if (present) begin nxt = 2; m_cnt = 0; end
            else if (m_cnt + 1 >= DLIM) begin nxt = 0; m_cnt = 0; end
            else m_cnt++;
        end else if (m_state == 0) begin
            if (present) begin nxt = 2; m_cnt = 0; end
        end else begin
            if (!present) begin nxt = 1; m_cnt = 0; end
            else if (m_cnt + 1 >= ICYC) begin nxt = 3; m_cnt = 0; end
            else m_cnt++;
        end
        m_flush = (nxt <= 1) && (nxt != m_state);
        m_state = nxt;
        void'(m_pipe.pop_back());
        m_pipe.push_front(pin);
        m_prev = lvl;
        if (rise) m_age = 0;
        else if (m_age < WIN) m_age++;
    endtask

    task automatic check(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("state", if_state_o, m_state);
        check("flush_req", flush_req_o, m_flush);
        check("flush_stat", flush_stat_o, m_flush);
        check("lreq_pass", lreq_pass_o, lreq_i && (m_state == 3));
        check("stat_pass", stat_pass_o, stat_evt_i && (m_state == 3));
    endtask

    int tick = 0;
    task automatic step(bit pin, bit rq, bit se);
        link_pwr_i = pin;
        lreq_i = rq;
        stat_evt_i = se;
        @(posedge clk);
        model_clock(pin, pulse_sel_i, isolated_i);
        @(negedge clk);
        compare();
        tick++;
    endtask

    task automatic level_run(int n, bit pin);
        for (int i = 0; i < n; i++) step(pin, 1'b1, i[0]);
    endtask

    task automatic pulse_run(int n, int period);
        for (int i = 0; i < n; i++) step((i % period) == 0, 1'b1, 1'b1);
    endtask

    initial begin
        #20000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        check("reset state", if_state_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 + R2: level high, observe latency and init length
        tag = "R9";
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("still disabled before sync", if_state_o, 0);
        step(1'b1, 1'b0, 1'b0);
        check("init after sync", if_state_o, 2);
        tag = "R2";
        level_run(ICYC + 2, 1'b1);
        check("operational", if_state_o, 3);

        // R6: gates toggled while operational
        tag = "R6";
        for (int i = 0; i < 8; i++) step(1'b1, i[0], i[1]);

        // R3 + R5: short dropout with requests held high
        tag = "R3";
        level_run(3, 1'b0);
        tag = "R5";
        level_run(ICYC + 6, 1'b1);
        check("back operational", if_state_o, 3);

        // R4: long dropout, then dropouts around the limit
        tag = "R4";
        level_run(DLIM + 6, 1'b0);
        check("disabled", if_state_o, 0);
        for (int g = DLIM - 2; g <= DLIM + 2; g++) begin
            level_run(ICYC + 6, 1'b1);
            level_run(g, 1'b0);
        end

        // R10: dropout during init
        tag = "R10";
        level_run(SYNC + 3, 1'b1);
        level_run(2, 1'b0);
        level_run(ICYC + 8, 1'b1);

        // R7: pulsed mode, fast pulses hold, slow ones drop
        tag = "R7";
        pulse_sel_i = 1'b1;
        pulse_run(40, 5);
        check("pulsed operational", if_state_o, 3);
        pulse_run(60, WIN + 6);
        pulse_run(40, WIN);
        pulse_run(40, WIN + 1);
        pulse_run(DLIM + 10, 1000);

        // R8: isolation forces pulsed mode
        tag = "R8";
        pulse_sel_i = 1'b0;
        isolated_i = 1'b1;
        level_run(WIN + DLIM + 10, 1'b1);
        check("steady high not present", if_state_o, 0);
        pulse_run(40, 4);
        check("isolated pulses operational", if_state_o, 3);
        isolated_i = 1'b0;
        level_run(DLIM + 10, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule